// File: doc/BRIEF.md
# Periodic Interrupt and Square-Wave Generator

This block divides a 32.768 kHz clock-enable strobe to produce a programmable periodic event and a matching square wave. A 4-bit rate code selects one divider tap. Both outputs share that tap. The code map is not monotonic: codes 1 and 2 give slow rates, code 3 jumps to the fastest divided rate, and each code above 3 halves the rate. On every completed period the block emits a one-cycle flag-set pulse. A separate enable decides whether that pulse also appears as an interrupt request.

The square-wave output has its own enable. A passthrough mode routes the raw 32.768 kHz strobe to the square-wave pin without division. A synchronous divider reset holds every stage at zero. Counting, and the period timing, restart from the moment that reset is released. The surrounding timekeeper supplies the strobe, the enables and the rate code.

Top module: `periodic_rate_gen`

## Requirements
- R1: Rate code 0 disables the divided outputs. `pflag_set_o` and `irq_o` stay low, and with passthrough off `sqw_o` stays low.
- R2: Rate code 1 selects a period of 128 strobes (256 Hz). Rate code 2 selects a period of 256 strobes (128 Hz).
- R3: Rate code c, for c from 3 to 15, selects a period of 4·2^(c-3) strobes. This runs from 8.192 kHz at code 3 down to 2 Hz at code 15.
- R4: With the square wave enabled, `sqw_o` is low for the first half of each period and high for the second half. The period is counted from divider-reset release.
- R5: `pflag_set_o` is high for exactly one cycle per period. The first pulse follows the clock edge that accepts the period's last strobe after divider-reset release. That strobe is strobe number P, where P is the period.
- R6: `irq_o` pulses in the same cycle as `pflag_set_o` only while `pie_en_i` is 1. It is never high otherwise.
- R7: With `sqw_en_i` at 0, `sqw_o` is low. `pflag_set_o` keeps pulsing at the selected rate.
- R8: With `sqw_en_i` and `pass32k_i` both at 1, `sqw_o` equals `tick32k_i` for any rate code.
- R9: The divider advances only on cycles where `tick32k_i` is 1.
- R10: While `div_rst_i` is 1, no flag pulse occurs and the divided square wave stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick32k_i | input | 1 | 32.768 kHz clock-enable strobe |
| rate_sel_i | input | 4 | Rate code |
| sqw_en_i | input | 1 | Square-wave output enable |
| pie_en_i | input | 1 | Periodic interrupt enable |
| pass32k_i | input | 1 | Route the raw strobe to the square-wave output |
| div_rst_i | input | 1 | Synchronous divider reset |
| sqw_o | output | 1 | Square-wave output |
| pflag_set_o | output | 1 | One-cycle periodic flag set pulse |
| irq_o | output | 1 | Periodic interrupt request pulse |

## Verification
Assertions check four properties on every cycle:
- a flag pulse never lasts two cycles;
- an interrupt never appears without a flag;
- rate code 0 and a held divider reset both suppress the flag;
- the divider holds still on cycles without a strobe.

Only the bench scenarios can show the rate map itself. For each code they measure the first-pulse latency and the pulse-to-pulse interval, and they count the square-wave high time across one period. The bench also covers passthrough tracking, gating by each enable, and the doubled period under a half-rate strobe.

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
  parameter int unsigned DIV_W = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick32k_i,
  input  logic [3:0] rate_sel_i,
  input  logic       sqw_en_i,
  input  logic       pie_en_i,
  input  logic       pass32k_i,
  input  logic       div_rst_i,
  output logic       sqw_o,
  output logic       pflag_set_o,
  output logic       irq_o
);

  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt_q;
  logic [3:0]       tap;
  logic [DIV_W-1:0] mask;
  logic             rate_on, wrap;
  logic             pf_q, irq_q;

  always_comb begin
    case (rate_sel_i)
      4'd0:    tap = 4'd0;
      4'd1:    tap = 4'd6;
      4'd2:    tap = 4'd7;
      default: tap = rate_sel_i - 4'd2;
    endcase
  end

  assign rate_on = (rate_sel_i != 4'd0);
  assign mask    = (ONE << (tap + 4'd1)) - ONE;
  assign wrap    = tick32k_i && rate_on && ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pf_q  <= 1'b0;
      irq_q <= 1'b0;
    end else if (div_rst_i) begin
      cnt_q <= '0;
      pf_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (tick32k_i) cnt_q <= cnt_q + ONE;
      pf_q  <= wrap;
      irq_q <= wrap && pie_en_i;
    end
  end

  assign pflag_set_o = pf_q;
  assign irq_o       = irq_q;
  assign sqw_o       = sqw_en_i && (pass32k_i ? tick32k_i : (rate_on && cnt_q[tap]));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pflag_set_o |=> !pflag_set_o);

  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pflag_set_o);

  assert_rate0_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel_i == 4'd0) |=> !pflag_set_o);

  assert_divrst_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst_i |=> (!pflag_set_o && cnt_q == '0));

  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick32k_i && !div_rst_i) |=> $stable(cnt_q));

endmodule

// File: tb/periodic_rate_gen_tb.sv
module periodic_rate_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [3:0] rate = 4'd0;
  logic sqw_en = 1'b0, pie_en = 1'b0, pass = 1'b0, div_rst = 1'b1;
  logic sqw, pf, irq;
  logic tick_slow = 1'b0;
  int checks = 0, errors = 0;
  int cyc = 0;

  localparam int unsigned PER [16] = '{0, 128, 256, 4, 8, 16, 32, 64, 128,
                                       256, 512, 1024, 2048, 4096, 8192, 16384};

  periodic_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tick32k_i(tick), .rate_sel_i(rate),
    .sqw_en_i(sqw_en), .pie_en_i(pie_en), .pass32k_i(pass), .div_rst_i(div_rst),
    .sqw_o(sqw), .pflag_set_o(pf), .irq_o(irq));

  always #2 clk = ~clk;

  always @(negedge clk) tick <= tick_slow ? ~tick : 1'b1;

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d exp<=190000 cycles", cyc);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tock();
    @(negedge clk); #1;
  endtask

  // count cycles until pf pulse; also count sqw high and irq samples
  task automatic wait_pulse(output int n, output int hi, output int irqs);
    n = 0; hi = 0; irqs = 0;
    for (int i = 0; i < 20000; i++) begin
      tock();
      n++;
      if (sqw) hi++;
      if (irq) irqs++;
      if (pf) break;
    end
  endtask

  task automatic restart();
    div_rst = 1'b1;
    tock(); tock();
    div_rst = 1'b0;
  endtask

  initial begin
    int n, hi, ir;
    int p;
    int bad;
    tock(); tock();
    check(!pf && !irq && !sqw, "R10 reset state", {pf, irq, sqw}, 0);
    rst_n = 1'b1;
    tock();
    check(!pf && !sqw, "R10 div reset held", {pf, sqw}, 0);

    // vector walk: rate codes 1..15
    sqw_en = 1'b1; pie_en = 1'b1;
    for (int c = 1; c < 16; c++) begin
      rate = 4'(c);
      p = int'(PER[c]);
      restart();
      wait_pulse(n, hi, ir);
      check(n == p, (c < 3) ? "R2 first-pulse latency" : "R3 first-pulse latency", n, p);
      check(hi == p / 2, "R4 sqw high time", hi, p / 2);
      check(ir == 1, "R6 irq with flag", ir, 1);
      tock();
      check(!pf, "R5 single-cycle pulse", pf, 0);
      wait_pulse(n, hi, ir);
      check(n == p - 1, (c < 3) ? "R2 period" : "R3 period", n + 1, p);
    end

    // R1: code 0 quiet
    rate = 4'd0;
    restart();
    bad = 0;
    for (int i = 0; i < 2000; i++) begin
      tock();
      if (pf || irq || sqw) bad++;
    end
    check(bad == 0, "R1 code 0 quiet", bad, 0);

    // R6: pie off
    rate = 4'd3; pie_en = 1'b0;
    restart();
    bad = 0; n = 0;
    for (int i = 0; i < 40; i++) begin
      tock();
      if (irq) bad++;
      if (pf) n++;
    end
    check(bad == 0, "R6 irq gated off", bad, 0);
    check(n == 10, "R6 flag still pulses", n, 10);

    // R7: sqw off
    sqw_en = 1'b0;
    restart();
    bad = 0; n = 0;
    for (int i = 0; i < 40; i++) begin
      tock();
      if (sqw) bad++;
      if (pf) n++;
    end
    check(bad == 0, "R7 sqw held low", bad, 0);
    check(n == 10, "R7 flag unaffected", n, 10);

    // R8: passthrough follows strobe for any code
    sqw_en = 1'b1; pass = 1'b1; tick_slow = 1'b1;
    for (int c = 0; c < 16; c += 5) begin
      rate = 4'(c);
      bad = 0;
      for (int i = 0; i < 8; i++) begin
        tock();
        if (sqw !== tick) bad++;
      end
      check(bad == 0, "R8 passthrough", bad, 0);
    end
    pass = 1'b0;

    // R9: half-rate strobe doubles the period
    rate = 4'd3;
    restart();
    wait_pulse(n, hi, ir);
    wait_pulse(n, hi, ir);
    check(n == 8, "R9 half-rate strobe period", n, 8);

    // R9: no strobe, divider frozen
    tick_slow = 1'b0;
    restart();
    tock(); tock();
    force tick = 1'b0;
    bad = 0;
    hi = sqw;
    for (int i = 0; i < 30; i++) begin
      tock();
      if (pf || sqw !== hi) bad++;
    end
    release tick;
    check(bad == 0, "R9 frozen without strobe", bad, 0);

    // R10: held divider reset
    div_rst = 1'b1;
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      tock();
      if (pf || sqw) bad++;
    end
    check(bad == 0, "R10 no activity under divider reset", bad, 0);
    div_rst = 1'b0;

    finish_run();
  end
endmodule